// File: doc/BRIEF.md
# Multiplexed-Bus RAM and I/O Register Front End

This block sits between a multiplexed address/data bus and the inside of a combined memory and I/O peripheral. An address strobe carries the address on the shared lines. The block holds that address, together with the chip enable and the memory/IO select, from the strobe's falling edge until the next address phase. The read and write strobes that follow go either to a 256-byte static RAM or to a small I/O register file.

The register file has one address that does two jobs. A write there loads a command byte, and that byte can never be read back. A read there returns a status byte, and that byte can never be written. The command byte sets the direction of ports A and B, the mode code of port C and the interrupt enables of ports A and B. It also carries a two-bit timer command. Three port data registers follow. The timer is reached only through write pulses, read inputs and a flag-clear pulse.

Everything is sampled on one clock. Each strobe is taken on the clock edge where it is first seen high.

Top module: `mbus_front`

## Requirements
- R1: The address, chip enable and IO select are captured from their values in the last clock cycle that `addr_stb` was high, once `addr_stb` is seen low. They are held unchanged while `addr_stb` stays low, whatever happens on `bus_in`, `chip_en` or `io_sel`.
- R2: With the captured select low, a write stores `bus_in` into a 256 x 8 RAM at the captured address. A later read returns that byte on `bus_out`.
- R3: Reset (`rst_n` low at a clock edge) clears the command byte. After reset, `prt_a_dir`, `prt_b_dir`, `irq_en_a` and `irq_en_b` are 0, `prt_c_mode` is 00 and `tmr_clr` is 0.
- R4: An I/O write with captured address bits [2:0] = 000 loads the command byte. Its bits map as follows: bit 0 drives `prt_a_dir`, bit 1 drives `prt_b_dir`, bits 3:2 drive `prt_c_mode`, bit 4 drives `irq_en_a` and bit 5 drives `irq_en_b`. During that write cycle, bits 7:6 appear on `tmr_cmd` and `tmr_cmd_wr` pulses high.
- R5: An I/O read with address bits [2:0] = 000 returns the status byte and never the command byte. The status bits are: bit 0 `prt_a_req`, bit 1 `prt_a_full`, bit 2 `irq_en_a`, bit 3 `prt_b_req`, bit 4 `prt_b_full`, bit 5 `irq_en_b`, bit 6 `tmr_flag`, and bit 7 = 0.
- R6: I/O addresses 001, 010 and 011 hold the port A, B and C output registers. A read of port A or port B returns its register when the port's direction bit is 1 and the input pins when it is 0. A read of port C returns the pins in mode 00 and the register in any other mode, zero-extended.
- R7: An I/O write to 100 or 101 raises `tmr_wr_lo` or `tmr_wr_hi` for that write cycle, with the byte on `tmr_wdata`. A read of 100 or 101 returns `tmr_lo` or `tmr_hi`.
- R8: I/O addresses 110 and 111 read as 0, and a write to either one changes no register.
- R9: An I/O read of 000 raises `tmr_clr` for exactly one cycle, in the cycle after the read strobe is first seen. This happens once per read strobe, however long the strobe is held.
- R10: `bus_oe` is high only while `rd_en` is high and the captured chip enable is 1. With the captured chip enable at 0, writes change nothing.
- R11: A write takes effect once per write strobe, on its first cycle. I/O decoding uses only address bits [2:0], so the upper five address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_stb | input | 1 | Address strobe; the address is captured when it falls |
| bus_in | input | 8 | Shared address/data lines, inbound |
| bus_out | output | 8 | Read data |
| bus_oe | output | 1 | Read data drive enable |
| chip_en | input | 1 | Chip enable, active high, captured with the address |
| io_sel | input | 1 | 1 = I/O registers, 0 = RAM, captured with the address |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| prt_a_in | input | 8 | Port A pins |
| prt_a_out | output | 8 | Port A output register |
| prt_a_dir | output | 1 | Port A direction (1 = output) |
| prt_b_in | input | 8 | Port B pins |
| prt_b_out | output | 8 | Port B output register |
| prt_b_dir | output | 1 | Port B direction (1 = output) |
| prt_c_in | input | 6 | Port C pins |
| prt_c_out | output | 6 | Port C output register |
| prt_c_mode | output | 2 | Port C mode code |
| irq_en_a | output | 1 | Port A interrupt enable |
| irq_en_b | output | 1 | Port B interrupt enable |
| prt_a_req | input | 1 | Port A interrupt request |
| prt_a_full | input | 1 | Port A buffer full/empty |
| prt_b_req | input | 1 | Port B interrupt request |
| prt_b_full | input | 1 | Port B buffer full/empty |
| tmr_cmd | output | 2 | Timer command field |
| tmr_cmd_wr | output | 1 | Timer command write pulse |
| tmr_wdata | output | 8 | Timer write byte |
| tmr_wr_lo | output | 1 | Timer low byte write pulse |
| tmr_wr_hi | output | 1 | Timer high byte write pulse |
| tmr_lo | input | 8 | Timer low byte for reads |
| tmr_hi | input | 8 | Timer high byte for reads |
| tmr_flag | input | 1 | Timer interrupt flag |
| tmr_clr | output | 1 | Timer flag clear pulse |

## Verification
The bench writes a command byte whose bits are all distinct, then reads the same address. A design that decoded the shared address wrongly would return the command byte, or let the status byte be overwritten. The status read is held for two cycles, which catches a flag-clear pulse that follows the strobe level instead of its first cycle. The bus lines and selects are changed after the address strobe falls, and unused addresses and a deselected chip are written and then read back. This exposes a latch that stays transparent, writes that leak into other registers, and an output enable or write path that ignores the captured chip enable. Port reads are checked in both directions and in two port C modes, so a swapped pin/register mux shows up as a wrong byte.

// File: rtl/mbus_pkg.sv
// Shared types for the multiplexed-bus front end.
// Assumes the I/O register file is decoded from the low three address bits.
package mbus_pkg;
    localparam int IO_SEL_W = 3;

    typedef enum logic [IO_SEL_W-1:0] {
        IO_CTL  = 3'd0,
        IO_PA   = 3'd1,
        IO_PB   = 3'd2,
        IO_PC   = 3'd3,
        IO_TLO  = 3'd4,
        IO_THI  = 3'd5,
        IO_RSV6 = 3'd6,
        IO_RSV7 = 3'd7
    } io_reg_e;
endpackage

// File: rtl/mbus_latch.sv
// Address phase capture: holds address, chip enable and IO select.
// Assumes the strobe is sampled on clk; the values taken are those present
// during the last cycle the strobe was high, latched once it is seen low.
module mbus_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_stb,
    input  logic [DW-1:0] bus_in,
    input  logic          chip_en,
    input  logic          io_sel,
    output logic [DW-1:0] lat_addr,
    output logic          lat_cs,
    output logic          lat_io
);
    logic          stb_d;
    logic [DW-1:0] addr_d;
    logic          cs_d;
    logic          io_d;
    logic          fall;

    assign fall = stb_d && !addr_stb;

    // Delay the strobe and the address phase inputs by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_d  <= 1'b0;
            addr_d <= '0;
            cs_d   <= 1'b0;
            io_d   <= 1'b0;
        end else begin
            stb_d  <= addr_stb;
            addr_d <= bus_in;
            cs_d   <= chip_en;
            io_d   <= io_sel;
        end
    end

    // Capture the delayed values on the strobe's falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_cs   <= 1'b0;
            lat_io   <= 1'b0;
        end else if (fall) begin
            lat_addr <= addr_d;
            lat_cs   <= cs_d;
            lat_io   <= io_d;
        end
    end

    a_r1_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb_d && !addr_stb) |=> $stable(lat_addr) && $stable(lat_cs) && $stable(lat_io));
endmodule

// File: rtl/mbus_ram.sv
// Byte-wide static RAM behind the bus, 2**AW entries.
// Assumes one write per strobe pulse and an asynchronous read port.
module mbus_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    // Store the write byte at the addressed entry.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/mbus_regs.sv
// I/O register file: write-only command, read-only status at one address,
// three port registers and the timer byte hookup.
// Assumes io_we and rd_first are single-cycle pulses, qualified by chip enable.
module mbus_regs
    import mbus_pkg::*;
#(
    parameter int DW  = 8,
    parameter int PCW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_we,
    input  logic                rd_first,
    input  logic [IO_SEL_W-1:0] sel,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    input  logic [DW-1:0]       prt_a_in,
    output logic [DW-1:0]       prt_a_out,
    output logic                prt_a_dir,
    input  logic [DW-1:0]       prt_b_in,
    output logic [DW-1:0]       prt_b_out,
    output logic                prt_b_dir,
    input  logic [PCW-1:0]      prt_c_in,
    output logic [PCW-1:0]      prt_c_out,
    output logic [1:0]          prt_c_mode,
    output logic                irq_en_a,
    output logic                irq_en_b,
    input  logic                prt_a_req,
    input  logic                prt_a_full,
    input  logic                prt_b_req,
    input  logic                prt_b_full,
    output logic [1:0]          tmr_cmd,
    output logic                tmr_cmd_wr,
    output logic [DW-1:0]       tmr_wdata,
    output logic                tmr_wr_lo,
    output logic                tmr_wr_hi,
    input  logic [DW-1:0]       tmr_lo,
    input  logic [DW-1:0]       tmr_hi,
    input  logic                tmr_flag,
    output logic                tmr_clr
);
    io_reg_e        rsel;
    logic [DW-1:0]  cmd_q;
    logic [DW-1:0]  stat;
    logic [DW-1:0]  pc_rd;

    assign rsel = io_reg_e'(sel);

    // Load the addressed writable register on an I/O write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            prt_a_out <= '0;
            prt_b_out <= '0;
            prt_c_out <= '0;
        end else if (io_we) begin
            case (rsel)
                IO_CTL:  cmd_q     <= wdata;
                IO_PA:   prt_a_out <= wdata;
                IO_PB:   prt_b_out <= wdata;
                IO_PC:   prt_c_out <= wdata[PCW-1:0];
                default: ;
            endcase
        end
    end

    // Raise the timer flag clear for one cycle after a status read starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_clr <= 1'b0;
        end else begin
            tmr_clr <= rd_first && (rsel == IO_CTL);
        end
    end

    assign prt_a_dir  = cmd_q[0];
    assign prt_b_dir  = cmd_q[1];
    assign prt_c_mode = cmd_q[3:2];
    assign irq_en_a   = cmd_q[4];
    assign irq_en_b   = cmd_q[5];

    assign tmr_cmd    = wdata[7:6];
    assign tmr_cmd_wr = io_we && (rsel == IO_CTL);
    assign tmr_wdata  = wdata;
    assign tmr_wr_lo  = io_we && (rsel == IO_TLO);
    assign tmr_wr_hi  = io_we && (rsel == IO_THI);

    assign stat  = {1'b0, tmr_flag, irq_en_b, prt_b_full, prt_b_req,
                    irq_en_a, prt_a_full, prt_a_req};
    assign pc_rd = (prt_c_mode == 2'b00) ? prt_c_in : prt_c_out;

    // Select the read byte for the addressed I/O register.
    always_comb begin
        case (rsel)
            IO_CTL:  rdata = stat;
            IO_PA:   rdata = prt_a_dir ? prt_a_out : prt_a_in;
            IO_PB:   rdata = prt_b_dir ? prt_b_out : prt_b_in;
            IO_PC:   rdata = {{(DW-PCW){1'b0}}, pc_rd};
            IO_TLO:  rdata = tmr_lo;
            IO_THI:  rdata = tmr_hi;
            default: rdata = '0;
        endcase
    end

    a_r4_cmd_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_we && sel == 3'd0) |=> $stable(cmd_q));
    a_r8_rsv_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && sel[2:1] == 2'b11) |=> $stable(cmd_q) && $stable(prt_a_out)
                                         && $stable(prt_b_out) && $stable(prt_c_out));
    a_r9_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr |=> !tmr_clr);
endmodule

// File: rtl/mbus_front.sv
// Top of the bus front end: captures the address phase, turns read and
// write strobes into single-cycle pulses and steers them to RAM or registers.
// Assumes strobes are synchronous to clk and active high.
module mbus_front #(
    parameter int DW  = 8,
    parameter int PCW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           addr_stb,
    input  logic [DW-1:0]  bus_in,
    output logic [DW-1:0]  bus_out,
    output logic           bus_oe,
    input  logic           chip_en,
    input  logic           io_sel,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [DW-1:0]  prt_a_in,
    output logic [DW-1:0]  prt_a_out,
    output logic           prt_a_dir,
    input  logic [DW-1:0]  prt_b_in,
    output logic [DW-1:0]  prt_b_out,
    output logic           prt_b_dir,
    input  logic [PCW-1:0] prt_c_in,
    output logic [PCW-1:0] prt_c_out,
    output logic [1:0]     prt_c_mode,
    output logic           irq_en_a,
    output logic           irq_en_b,
    input  logic           prt_a_req,
    input  logic           prt_a_full,
    input  logic           prt_b_req,
    input  logic           prt_b_full,
    output logic [1:0]     tmr_cmd,
    output logic           tmr_cmd_wr,
    output logic [DW-1:0]  tmr_wdata,
    output logic           tmr_wr_lo,
    output logic           tmr_wr_hi,
    input  logic [DW-1:0]  tmr_lo,
    input  logic [DW-1:0]  tmr_hi,
    input  logic           tmr_flag,
    output logic           tmr_clr
);
    import mbus_pkg::*;

    logic [DW-1:0] lat_addr;
    logic          lat_cs;
    logic          lat_io;
    logic          wr_q;
    logic          rd_q;
    logic          wr_first;
    logic          rd_first;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] reg_rdata;

    mbus_latch #(.DW(DW)) u_latch (
        .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .bus_in(bus_in),
        .chip_en(chip_en), .io_sel(io_sel),
        .lat_addr(lat_addr), .lat_cs(lat_cs), .lat_io(lat_io)
    );

    // Remember the previous strobe levels to find each strobe's first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_en;
            rd_q <= rd_en;
        end
    end

    assign wr_first = wr_en && !wr_q && lat_cs;
    assign rd_first = rd_en && !rd_q && lat_cs && lat_io;

    mbus_ram #(.AW(DW), .DW(DW)) u_ram (
        .clk(clk), .we(wr_first && !lat_io), .addr(lat_addr),
        .wdata(bus_in), .rdata(ram_rdata)
    );

    mbus_regs #(.DW(DW), .PCW(PCW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .io_we(wr_first && lat_io), .rd_first(rd_first),
        .sel(lat_addr[IO_SEL_W-1:0]), .wdata(bus_in), .rdata(reg_rdata),
        .prt_a_in(prt_a_in), .prt_a_out(prt_a_out), .prt_a_dir(prt_a_dir),
        .prt_b_in(prt_b_in), .prt_b_out(prt_b_out), .prt_b_dir(prt_b_dir),
        .prt_c_in(prt_c_in), .prt_c_out(prt_c_out), .prt_c_mode(prt_c_mode),
        .irq_en_a(irq_en_a), .irq_en_b(irq_en_b),
        .prt_a_req(prt_a_req), .prt_a_full(prt_a_full),
        .prt_b_req(prt_b_req), .prt_b_full(prt_b_full),
        .tmr_cmd(tmr_cmd), .tmr_cmd_wr(tmr_cmd_wr), .tmr_wdata(tmr_wdata),
        .tmr_wr_lo(tmr_wr_lo), .tmr_wr_hi(tmr_wr_hi),
        .tmr_lo(tmr_lo), .tmr_hi(tmr_hi), .tmr_flag(tmr_flag), .tmr_clr(tmr_clr)
    );

    assign bus_oe  = rd_en && lat_cs;
    assign bus_out = lat_io ? reg_rdata : ram_rdata;

    a_r5_status_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && lat_io && lat_addr[2:0] == 3'b000) |-> (bus_out[7] == 1'b0));
    a_r11_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_first |=> !wr_first);
    a_r10_no_oe_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_cs |-> !bus_oe);
endmodule

// File: tb/mbus_front_bench.sv
// Directed bench for mbus_front: one task per scenario.
module mbus_front_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_stb = 1'b0;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       chip_en = 1'b0;
    logic       io_sel = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] prt_a_in = 8'h3C;
    logic [7:0] prt_a_out;
    logic       prt_a_dir;
    logic [7:0] prt_b_in = 8'hC3;
    logic [7:0] prt_b_out;
    logic       prt_b_dir;
    logic [5:0] prt_c_in = 6'h15;
    logic [5:0] prt_c_out;
    logic [1:0] prt_c_mode;
    logic       irq_en_a, irq_en_b;
    logic       prt_a_req = 1'b0, prt_a_full = 1'b0;
    logic       prt_b_req = 1'b0, prt_b_full = 1'b0;
    logic [1:0] tmr_cmd;
    logic       tmr_cmd_wr;
    logic [7:0] tmr_wdata;
    logic       tmr_wr_lo, tmr_wr_hi;
    logic [7:0] tmr_lo = 8'h9E;
    logic [7:0] tmr_hi = 8'h27;
    logic       tmr_flag = 1'b0;
    logic       tmr_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Pulses seen during the last write cycle
    logic       s_cmd_wr, s_wr_lo, s_wr_hi;
    logic [1:0] s_cmd;
    logic [7:0] s_wdata;
    // Results of the last read
    logic [7:0] r_data;
    logic       r_oe, r_clr1, r_clr2;

    always #10 clk = ~clk;

    mbus_front u_mbus_front (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_addr(input logic io, input logic cs, input logic [7:0] a);
        @(negedge clk);
        addr_stb = 1'b1; bus_in = a; chip_en = cs; io_sel = io;
        @(negedge clk);
        addr_stb = 1'b0; bus_in = ~a; chip_en = ~cs; io_sel = ~io;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] d);
        @(negedge clk);
        bus_in = d; wr_en = 1'b1;
        #1;
        s_cmd_wr = tmr_cmd_wr; s_wr_lo = tmr_wr_lo; s_wr_hi = tmr_wr_hi;
        s_cmd = tmr_cmd; s_wdata = tmr_wdata;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd();
        @(negedge clk);
        rd_en = 1'b1;
        #1;
        r_data = bus_out; r_oe = bus_oe;
        @(posedge clk); #1; r_clr1 = tmr_clr;
        @(posedge clk); #1; r_clr2 = tmr_clr;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R3 dir a", prt_a_dir, 0);
        chk("R3 dir b", prt_b_dir, 0);
        chk("R3 mode c", prt_c_mode, 0);
        chk("R3 irq en", {irq_en_a, irq_en_b}, 0);
        chk("R3 clr", tmr_clr, 0);
        chk("R10 oe idle", bus_oe, 0);
    endtask

    task automatic t_ram();
        set_addr(1'b0, 1'b1, 8'h00); bus_wr(8'h11);
        set_addr(1'b0, 1'b1, 8'hFF); bus_wr(8'hEE);
        set_addr(1'b0, 1'b1, 8'h07); bus_wr(8'h77);
        set_addr(1'b0, 1'b1, 8'h00); bus_rd();
        chk("R2 ram 00", r_data, 8'h11);
        chk("R10 oe read", r_oe, 1);
        set_addr(1'b0, 1'b1, 8'hFF); bus_rd();
        chk("R2 ram ff", r_data, 8'hEE);
        chk("R1 latch held", r_data, 8'hEE);
        set_addr(1'b0, 1'b1, 8'h07); bus_rd();
        chk("R2 ram 07 not io", r_data, 8'h77);
    endtask

    task automatic t_cmd_status();
        set_addr(1'b1, 1'b1, 8'h00); bus_wr(8'b1001_0110);
        chk("R4 cmd pulse", s_cmd_wr, 1);
        chk("R4 tmr cmd", s_cmd, 2'b10);
        chk("R4 dir a", prt_a_dir, 0);
        chk("R4 dir b", prt_b_dir, 1);
        chk("R4 mode c", prt_c_mode, 2'b01);
        chk("R4 irq en", {irq_en_b, irq_en_a}, 2'b01);
        prt_a_req = 1'b1; prt_a_full = 1'b0; prt_b_req = 1'b0; prt_b_full = 1'b1;
        tmr_flag = 1'b1;
        bus_rd();
        chk("R5 status", r_data, 8'b0101_0101);
        chk("R9 clr first", r_clr1, 1);
        chk("R9 clr once", r_clr2, 0);
        set_addr(1'b1, 1'b1, 8'hF8); bus_wr(8'h00);
        chk("R11 upper bits ignored", {prt_b_dir, irq_en_a}, 0);
        tmr_flag = 1'b0;
        bus_rd();
        chk("R5 status after cmd", r_data, 8'b0001_0001);
    endtask

    task automatic t_ports();
        set_addr(1'b1, 1'b1, 8'h00); bus_wr(8'b0000_0011);
        set_addr(1'b1, 1'b1, 8'h39); bus_wr(8'h5A);
        chk("R11 port a via high bits", prt_a_out, 8'h5A);
        bus_rd();
        chk("R6 port a output", r_data, 8'h5A);
        set_addr(1'b1, 1'b1, 8'h02); bus_wr(8'hA6);
        bus_rd();
        chk("R6 port b output", r_data, 8'hA6);
        set_addr(1'b1, 1'b1, 8'h00); bus_wr(8'h00);
        set_addr(1'b1, 1'b1, 8'h01); bus_rd();
        chk("R6 port a input", r_data, 8'h3C);
        set_addr(1'b1, 1'b1, 8'h02); bus_rd();
        chk("R6 port b input", r_data, 8'hC3);
        set_addr(1'b1, 1'b1, 8'h03); bus_wr(8'hEA);
        chk("R6 port c reg", prt_c_out, 6'h2A);
        bus_rd();
        chk("R6 port c mode 00 pins", r_data, 8'h15);
        set_addr(1'b1, 1'b1, 8'h00); bus_wr(8'b0000_1000);
        set_addr(1'b1, 1'b1, 8'h03); bus_rd();
        chk("R6 port c mode 10 reg", r_data, 8'h2A);
    endtask

    task automatic t_timer_rsv();
        set_addr(1'b1, 1'b1, 8'h04); bus_wr(8'h4D);
        chk("R7 wr lo", {s_wr_lo, s_wr_hi}, 2'b10);
        chk("R7 wdata", s_wdata, 8'h4D);
        bus_rd();
        chk("R7 rd lo", r_data, 8'h9E);
        chk("R9 no clr other addr", r_clr1, 0);
        set_addr(1'b1, 1'b1, 8'h05); bus_wr(8'h12);
        chk("R7 wr hi", {s_wr_lo, s_wr_hi}, 2'b01);
        bus_rd();
        chk("R7 rd hi", r_data, 8'h27);
        set_addr(1'b1, 1'b1, 8'h06); bus_wr(8'hFF);
        chk("R8 no cmd change", {prt_a_dir, prt_b_dir, irq_en_a, irq_en_b, prt_c_mode}, 6'b000010);
        bus_rd();
        chk("R8 rsv6 zero", r_data, 0);
        set_addr(1'b1, 1'b1, 8'h07); bus_wr(8'hFF);
        bus_rd();
        chk("R8 rsv7 zero", r_data, 0);
        chk("R8 port c kept", prt_c_out, 6'h2A);
    endtask

    task automatic t_deselect();
        set_addr(1'b1, 1'b0, 8'h01); bus_wr(8'h99);
        chk("R10 no write deselected", prt_a_out, 8'h5A);
        bus_rd();
        chk("R10 oe off deselected", r_oe, 0);
        chk("R10 no clr deselected", r_clr1, 0);
        set_addr(1'b0, 1'b0, 8'h07); bus_wr(8'h00);
        set_addr(1'b0, 1'b1, 8'h07); bus_rd();
        chk("R10 ram kept", r_data, 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_ram();
        t_cmd_status();
        t_ports();
        t_timer_rsv();
        t_deselect();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule